// File: doc/BRIEF.md
# Reset-Aware SMBus Management Slave

This block is a bit-level SMBus slave through which an external management controller reads a status byte and writes a control byte. A host-side reset sequencer works on the same block at the same time. Four host-side events reach it: a hardware reset pulse, an isolate level whose falling edge counts as a reset, a wake pulse that marks a low-power-to-active transition, and a software or selective reset pulse.

When any of these events lands while an SMBus transfer is under way, the slave aborts that transfer. Every read bit that is still to come, in the current byte and in later bytes, comes out as zero. Write bytes are NACKed and change nothing. The aborted state holds until the master issues a STOP or a repeated START. Afterwards the slave reports that it has re-initialized: it sets an init bit in the status byte, and after a wake it also pulls the active-low alert line. Reading the status byte clears both.

Top module: `smb_mgmt_slave`

## Requirements
- R1: The slave ACKs an address byte only when its upper 7 bits equal SLV_ADDR (default 7'h2C; bit 0 is 1 for read). For any other address it drives nothing in the ACK slot.
- R2: After an ACKed write address, each data byte D is ACKed and loads the status field from D[7:4] and receive-enable from D[0]. The new values appear on stat_o and rx_en_o.
- R3: After an ACKed read address, the first byte is {init, 3'b000, status field} and every later byte is {7'b0, receive-enable}. All bytes are sent MSB first. A master NACK ends the read.
- R4: sda_oe_o (1 pulls SDA low) changes only while synchronized SCL is low.
- R5: One cycle after a wake pulse, alert_no is low and the init bit is set.
- R6: A software reset pulse sets the init bit. It does not assert alert_no and leaves the status field and receive-enable unchanged.
- R7: A hardware reset pulse, a falling edge of isolate_i, or a wake pulse clears the status field and receive-enable one cycle later. A rising edge or a steady level of isolate_i has no effect.
- R8: Sending the status byte clears the init bit and releases alert_no.
- R9: When a reset event hits during a read, every later bit of the current byte and every later byte reads as zero.
- R10: When a reset event hits during a write, data bytes are NACKed and no register changes.
- R11: A STOP or a repeated START ends the aborted state, and the next transfer behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| scl_i | input | 1 | SMBus clock line |
| sda_i | input | 1 | SMBus data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| alert_no | output | 1 | Active-low SMBus alert |
| hw_rst_i | input | 1 | Hardware reset pulse |
| isolate_i | input | 1 | Isolate level; acts on its falling edge |
| wake_i | input | 1 | Low-power-to-active transition pulse |
| sw_rst_i | input | 1 | Software or selective reset pulse |
| rx_en_o | output | 1 | Receive-enable field |
| stat_o | output | 4 | Status field |

## Verification
The register effects of a host-side pulse appear one clock after the pulse. The bench raises each pulse at a falling clock edge and reads the outputs at the next falling edge. On the bus side, SCL and SDA pass through two flip-flops and an edge register, so the slave updates sda_oe_o about three cycles after a raw SCL fall. The bench therefore holds every SCL phase for six cycles and samples SDA only at the end of the high phase. It places abort events well inside a low phase, after the current bit is already on the line, so the zeros start with the next bit.

// File: rtl/smb_mgmt_pkg.sv
package smb_mgmt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK
  } smb_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int   W       = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file #(
  parameter int DW = 8,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hw_rst_i,
  input  logic          isolate_i,
  input  logic          wake_i,
  input  logic          sw_rst_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          stat_rd_i,
  output logic          init_evt_o,
  output logic [DW-1:0] stat_byte_o,
  output logic [DW-1:0] ctrl_byte_o,
  output logic          alert_no,
  output logic          rx_en_o,
  output logic [SW-1:0] stat_o
);
  localparam int PadW = DW - 1 - SW;

  logic          iso_q, init_q, alert_q, rx_en_q;
  logic [SW-1:0] stat_q;
  logic          iso_fall, hard_evt;

  assign iso_fall   = iso_q & ~isolate_i;
  assign hard_evt   = hw_rst_i | iso_fall | wake_i;
  assign init_evt_o = hard_evt | sw_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iso_q   <= 1'b0;
      init_q  <= 1'b0;
      alert_q <= 1'b0;
      rx_en_q <= 1'b0;
      stat_q  <= '0;
    end else begin
      iso_q <= isolate_i;
      if (hard_evt) begin
        rx_en_q <= 1'b0;
        stat_q  <= '0;
      end else if (wr_en_i) begin
        rx_en_q <= wr_data_i[0];
        stat_q  <= wr_data_i[DW-1 -: SW];
      end
      // set wins over the clearing read
      if (wake_i || sw_rst_i) init_q <= 1'b1;
      else if (stat_rd_i)     init_q <= 1'b0;
      if (wake_i)             alert_q <= 1'b1;
      else if (stat_rd_i)     alert_q <= 1'b0;
    end
  end

  assign stat_byte_o = {init_q, {PadW{1'b0}}, stat_q};
  assign ctrl_byte_o = {{(DW-1){1'b0}}, rx_en_q};
  assign alert_no    = ~alert_q;
  assign rx_en_o     = rx_en_q;
  assign stat_o      = stat_q;

  assert_alert_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alert_no) |-> $past(wake_i));
  assert_hard_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_evt |=> (!rx_en_o && stat_o == '0));
  assert_sw_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rst_i && !hard_evt && !wr_en_i) |=> ($stable(stat_o) && $stable(rx_en_o)));
  assert_init_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !wake_i && !sw_rst_i) |=> (!stat_byte_o[DW-1] && alert_no));
endmodule

// File: rtl/smb_bit_engine.sv
module smb_bit_engine
  import smb_mgmt_pkg::*;
#(
  parameter int         DW       = 8,
  parameter logic [6:0] SLV_ADDR = 7'h2C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          init_evt_i,
  input  logic [DW-1:0] stat_byte_i,
  input  logic [DW-1:0] ctrl_byte_i,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic          stat_rd_o,
  output logic          sda_oe_o
);
  localparam int            CW    = $clog2(DW + 1);
  localparam logic [CW-1:0] BIT_N = CW'(DW);

  smb_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] shift_q, load_byte;
  logic          scl_d, sda_d, sda_oe_q, abort_q, rw_q, nack_q, rd_first_q;
  logic          scl_rise, scl_fall, start_det, stop_det, abort_eff, addr_hit, byte_end;

  assign scl_rise  = scl_s_i & ~scl_d;
  assign scl_fall  = ~scl_s_i & scl_d;
  assign start_det = scl_s_i & scl_d & sda_d & ~sda_s_i;
  assign stop_det  = scl_s_i & scl_d & ~sda_d & sda_s_i;
  assign abort_eff = abort_q | init_evt_i;
  assign addr_hit  = (shift_q[DW-1:1] == SLV_ADDR);
  assign byte_end  = scl_fall && (cnt_q == BIT_N);
  assign load_byte = abort_eff ? '0 : (rd_first_q ? stat_byte_i : ctrl_byte_i);

  assign wr_en_o   = (state_q == S_WR) && byte_end && !abort_eff;
  assign wr_data_o = shift_q;
  assign stat_rd_o = (state_q == S_AACK) && scl_fall && rw_q && !abort_eff;
  assign sda_oe_o  = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; cnt_q <= '0; shift_q <= '0;
      scl_d <= 1'b1; sda_d <= 1'b1; sda_oe_q <= 1'b0;
      abort_q <= 1'b0; rw_q <= 1'b0; nack_q <= 1'b0; rd_first_q <= 1'b0;
    end else begin
      scl_d <= scl_s_i;
      sda_d <= sda_s_i;
      if (start_det) begin
        state_q <= S_ADDR; cnt_q <= '0; abort_q <= 1'b0; sda_oe_q <= 1'b0;
      end else if (stop_det) begin
        state_q <= S_IDLE; abort_q <= 1'b0; sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          S_ADDR, S_WR: begin
            if (scl_rise && cnt_q != BIT_N) begin
              shift_q <= {shift_q[DW-2:0], sda_s_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (byte_end) begin
              cnt_q <= '0;
              if (state_q == S_WR) begin
                state_q  <= S_WACK;
                sda_oe_q <= ~abort_eff;
              end else if (addr_hit && !abort_eff) begin
                state_q <= S_AACK; sda_oe_q <= 1'b1;
                rw_q <= shift_q[0]; rd_first_q <= 1'b1;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              state_q <= S_RD; shift_q <= load_byte;
              sda_oe_q <= ~load_byte[DW-1]; rd_first_q <= 1'b0;
            end else begin
              state_q <= S_WR; sda_oe_q <= 1'b0;
            end
          end
          S_WACK: if (scl_fall) begin
            state_q <= S_WR; sda_oe_q <= 1'b0;
          end
          S_RD: begin
            if (scl_rise && cnt_q != BIT_N) cnt_q <= cnt_q + 1'b1;
            else if (byte_end) begin
              state_q <= S_RACK; sda_oe_q <= 1'b0; cnt_q <= '0;
            end else if (scl_fall) begin
              shift_q  <= {shift_q[DW-2:0], 1'b0};
              sda_oe_q <= ~shift_q[DW-2];
            end
          end
          S_RACK: begin
            if (scl_rise) nack_q <= sda_s_i;
            else if (scl_fall) begin
              if (nack_q) state_q <= S_IDLE;
              else begin
                state_q <= S_RD; shift_q <= load_byte;
                sda_oe_q <= ~load_byte[DW-1];
              end
            end
          end
          default: ;
        endcase
      end
      // abort: the rest of the current read byte turns to zeros
      if (init_evt_i && state_q == S_RD) shift_q <= '0;
      if (init_evt_i && state_q != S_IDLE) abort_q <= 1'b1;
    end
  end

  assert_sda_scl_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s_i));
  assert_abort_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> !wr_en_o);
  assert_abort_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((start_det || stop_det) && !init_evt_i) |=> !abort_q);
  assert_nack_foreign_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ADDR && byte_end && !addr_hit) |=> !sda_oe_o);
endmodule

// File: rtl/smb_mgmt_slave.sv
module smb_mgmt_slave #(
  parameter int         DW       = 8,
  parameter int         SW       = 4,
  parameter logic [6:0] SLV_ADDR = 7'h2C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          alert_no,
  input  logic          hw_rst_i,
  input  logic          isolate_i,
  input  logic          wake_i,
  input  logic          sw_rst_i,
  output logic          rx_en_o,
  output logic [SW-1:0] stat_o
);
  logic [1:0]    bus_s;
  logic          init_evt, wr_en, stat_rd;
  logic [DW-1:0] wr_data, stat_byte, ctrl_byte;

  smb_sync #(.W(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  smb_bit_engine #(.DW(DW), .SLV_ADDR(SLV_ADDR)) u_engine (
    .clk_i, .rst_ni,
    .scl_s_i(bus_s[1]), .sda_s_i(bus_s[0]),
    .init_evt_i(init_evt), .stat_byte_i(stat_byte), .ctrl_byte_i(ctrl_byte),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .stat_rd_o(stat_rd), .sda_oe_o
  );

  smb_reg_file #(.DW(DW), .SW(SW)) u_regs (
    .clk_i, .rst_ni, .hw_rst_i, .isolate_i, .wake_i, .sw_rst_i,
    .wr_en_i(wr_en), .wr_data_i(wr_data), .stat_rd_i(stat_rd),
    .init_evt_o(init_evt), .stat_byte_o(stat_byte), .ctrl_byte_o(ctrl_byte),
    .alert_no, .rx_en_o, .stat_o
  );
endmodule

// File: tb/tb_smb_mgmt_slave.sv
module tb_smb_mgmt_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [7:0] A_WR = 8'h58, A_RD = 8'h59, A_BAD = 8'h5A;

  typedef struct packed { logic [7:0] wr; logic [7:0] exp0; logic [7:0] exp1; } vec_t;
  localparam vec_t VECS [4] = '{
    '{8'hA1, 8'h0A, 8'h01}, '{8'h50, 8'h05, 8'h00},
    '{8'hF0, 8'h0F, 8'h00}, '{8'h3F, 8'h03, 8'h01}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic hw = 1'b0, iso = 1'b0, wake = 1'b0, sw = 1'b0;
  logic sda_oe, alert_n, rx_en;
  logic [3:0] stat;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_mgmt_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_m & ~sda_oe),
    .sda_oe_o(sda_oe), .alert_no(alert_n), .hw_rst_i(hw), .isolate_i(iso),
    .wake_i(wake), .sw_rst_i(sw), .rx_en_o(rx_en), .stat_o(stat)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    repeat (Q) @(negedge clk);
  endtask

  task automatic pulse(int kind);
    @(negedge clk);
    case (kind) 0: hw = 1'b1; 1: wake = 1'b1; default: sw = 1'b1; endcase
    @(negedge clk);
    hw = 1'b0; wake = 1'b0; sw = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; step(); scl = 1'b1; step(); sda_m = 1'b0; step(); scl = 1'b0; step();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; step(); scl = 1'b1; step(); sda_m = 1'b1; step();
  endtask

  task automatic send_byte(logic [7:0] b, int evt_idx, int kind, output logic ack);
    for (int i = 0; i < 8; i++) begin
      sda_m = b[7-i]; step();
      if (i == evt_idx) pulse(kind);
      scl = 1'b1; step(); scl = 1'b0; step();
    end
    sda_m = 1'b1; step(); scl = 1'b1; step();
    ack = sda_oe;
    scl = 1'b0; step();
  endtask

  task automatic recv_byte(logic nack, int evt_idx, int kind, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i == evt_idx) pulse(kind);
      scl = 1'b1; step();
      b[7-i] = ~sda_oe;
      scl = 1'b0; step();
    end
    sda_m = nack; step(); scl = 1'b1; step(); scl = 1'b0; step(); sda_m = 1'b1;
  endtask

  task automatic wr_txn(logic [7:0] d, string tag);
    logic a;
    bus_start();
    send_byte(A_WR, -1, 0, a); check({tag, " addr ack"}, a, 1);
    send_byte(d, -1, 0, a);    check({tag, " data ack"}, a, 1);
    bus_stop();
  endtask

  task automatic rd_txn(output logic [7:0] b0, output logic [7:0] b1);
    logic a;
    bus_start();
    send_byte(A_RD, -1, 0, a);
    recv_byte(1'b0, -1, 0, b0);
    recv_byte(1'b1, -1, 0, b1);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] b0, b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R7 reset stat", stat, 0);
    check("R7 reset rx_en", rx_en, 0);
    check("R5 reset alert", alert_n, 1);
    check("R4 reset sda_oe", sda_oe, 0);

    // R1 foreign address
    bus_start();
    send_byte(A_BAD, -1, 0, a); check("R1 foreign nack", a, 0);
    bus_stop();

    // R2 / R3 vector table
    foreach (VECS[k]) begin
      wr_txn(VECS[k].wr, "R2");
      check("R2 stat_o", stat, 32'(VECS[k].wr[7:4]));
      check("R2 rx_en_o", rx_en, 32'(VECS[k].wr[0]));
      rd_txn(b0, b1);
      check("R3 status byte", b0, 32'(VECS[k].exp0));
      check("R3 ctrl byte", b1, 32'(VECS[k].exp1));
    end

    // R5 / R7 wake
    pulse(1);
    check("R5 alert low", alert_n, 0);
    check("R7 wake clears stat", stat, 0);
    check("R7 wake clears rx_en", rx_en, 0);
    rd_txn(b0, b1);
    check("R5 init bit", b0, 32'h80);
    check("R8 alert released", alert_n, 1);
    rd_txn(b0, b1);
    check("R8 init cleared", b0, 32'h00);

    // R6 software reset
    wr_txn(8'hA1, "R6");
    pulse(2);
    check("R6 no alert", alert_n, 1);
    check("R6 stat kept", stat, 32'hA);
    rd_txn(b0, b1);
    check("R6 init set", b0, 32'h8A);
    check("R6 rx_en kept", b1, 32'h01);

    // R7 hardware reset and isolate
    pulse(0);
    check("R7 hw clears stat", stat, 0);
    check("R7 hw clears rx_en", rx_en, 0);
    wr_txn(8'hA1, "R7");
    @(negedge clk); iso = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 iso rise no effect", stat, 32'hA);
    iso = 1'b0;
    @(negedge clk);
    check("R7 iso fall clears stat", stat, 0);
    check("R7 iso fall clears rx_en", rx_en, 0);

    // R9 abort during read, R11 recovery after STOP
    wr_txn(8'hF1, "R9");
    bus_start();
    send_byte(A_RD, -1, 0, a);
    recv_byte(1'b0, 5, 2, b0);
    recv_byte(1'b1, -1, 0, b1);
    bus_stop();
    check("R9 partial zero byte", b0, 32'h0C);
    check("R9 later byte zero", b1, 32'h00);
    rd_txn(b0, b1);
    check("R11 read after stop", b0, 32'h8F);
    check("R11 ctrl after stop", b1, 32'h01);

    // R10 abort during write, R11 recovery by repeated START
    bus_start();
    send_byte(A_WR, -1, 0, a);
    send_byte(8'h20, 3, 2, a); check("R10 aborted byte nack", a, 0);
    send_byte(8'h40, -1, 0, a); check("R10 later byte nack", a, 0);
    check("R10 stat kept", stat, 32'hF);
    check("R10 rx_en kept", rx_en, 1);
    bus_start();
    send_byte(A_WR, -1, 0, a); check("R11 rep start addr ack", a, 1);
    send_byte(8'h50, -1, 0, a); check("R11 rep start data ack", a, 1);
    bus_stop();
    check("R11 stat written", stat, 32'h5);
    check("R11 rx_en written", rx_en, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule